// File: doc/BRIEF.md
# Fault-Located Ripple-Borrow Subtractor

The block subtracts two W-bit operands and an incoming borrow with a chain of one-bit cells. Each borrow passes from a cell to the cell above it. Every cell carries two independent self-checks, one for its difference net and one for its borrow-out net. Each check raises its own flag when the net disagrees with the cell's inputs. A fault can therefore be placed at a bit position and on a particular net, and faults on both nets of one cell are both seen.

The flags are gathered into a difference-flag vector and a borrow-flag vector. A priority encoder reduces the two vectors to a fault report: the lowest flagged bit, a net code and a valid bit. The result, both flag vectors and the report are captured in registers on an input strobe and appear one cycle later.

For verification, two per-bit masks can invert any cell's difference and borrow-out. The inversion sits between the cell's arithmetic and its checker. An inverted borrow-out is the value that travels on to the next cell.

Top module: `fault_located_subtractor`

## Requirements
- R1: With both masks zero, the cycle after `in_valid` the W+1-bit value {`borrow_out`,`diff`} equals `a - b - borrow_in` taken modulo 2^(W+1), so `borrow_out` is 1 exactly when `a < b + borrow_in`.
- R2: `out_valid` is `in_valid` delayed by one cycle. While `in_valid` is low, `diff`, `borrow_out`, the flag vectors and the report keep their last captured values.
- R3: With both masks zero, `flag_d` and `flag_b` are all zero for every operand combination.
- R4: `flag_d` equals the `inj_diff` mask applied one cycle earlier, whatever the operands and the other mask.
- R5: `flag_b` equals the `inj_borrow` mask applied one cycle earlier, whatever the operands and the other mask.
- R6: When both masks set the same bit, that bit is set in both `flag_d` and `flag_b`.
- R7: When any flag is set, `loc_index` is the lowest bit with a set flag. `loc_net` is 2'b01 if only the difference flag of that bit is set, 2'b10 if only its borrow flag is set, and 2'b11 if both are set.
- R8: `loc_valid` is 1 exactly when any bit of `flag_d` or `flag_b` is set. When it is 0, `loc_index` is 0 and `loc_net` is 2'b00.
- R9: A synchronous active-high `rst` clears every output to zero at the next clock edge.
- R10: An injected difference fault inverts that bit of `diff`. An injected borrow fault inverts that cell's borrow-out, which becomes the borrow-in of the next cell, or `borrow_out` for the top bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe; operands are captured on this cycle |
| a | input | W | Minuend |
| b | input | W | Subtrahend |
| borrow_in | input | 1 | Borrow into bit 0 |
| inj_diff | input | W | Per-bit inversion of the difference net |
| inj_borrow | input | W | Per-bit inversion of the borrow-out net |
| out_valid | output | 1 | Registered results are new this cycle |
| diff | output | W | Registered difference |
| borrow_out | output | 1 | Registered borrow out of the top bit |
| flag_d | output | W | Per-bit difference fault flags |
| flag_b | output | W | Per-bit borrow fault flags |
| loc_valid | output | 1 | At least one flag is set |
| loc_index | output | max(1,clog2(W)) | Lowest flagged bit |
| loc_net | output | 2 | Net code of the reported bit |

## Verification
The bench builds the block with W = 4. This width keeps the full operand space of 512 combinations of a, b and borrow_in small enough to sweep completely, so the fault-free checks cover every input pattern of a cell at every position along the chain. At this width, a single-fault and a same-bit double-fault pass at each of the four positions is cheap. So are all pairs of different faulty bits, which test the lowest-index rule of the report and the way an injected borrow moves the bits above it.

// File: rtl/fls_pkg.sv
package fls_pkg;

  typedef enum logic [1:0] {
    NET_NONE   = 2'b00,
    NET_DIFF   = 2'b01,
    NET_BORROW = 2'b10,
    NET_BOTH   = 2'b11
  } net_code_t;

  function automatic int idx_bits(input int width);
    return (width > 1) ? $clog2(width) : 1;
  endfunction

endpackage

// File: rtl/fls_cell.sv
module fls_cell (
  input  logic bit_a,
  input  logic bit_b,
  input  logic brw_i,
  input  logic flip_d,
  input  logic flip_o,
  output logic dif_o,
  output logic brw_o,
  output logic err_d,
  output logic err_o
);

  logic dif_raw, brw_raw;
  logic par_ai, cmp_db, cmp_ob, odd_mix;

  // arithmetic part
  assign dif_raw = bit_a ^ bit_b ^ brw_i;
  assign brw_raw = (~bit_a & bit_b) | (~bit_a & brw_i) | (bit_b & brw_i);

  // fault insertion between arithmetic and checker
  assign dif_o = dif_raw ^ flip_d;
  assign brw_o = brw_raw ^ flip_o;

  // difference checker: (a ^ bin) must equal (d ^ b)
  assign par_ai = bit_a ^ brw_i;
  assign cmp_db = ~(dif_o ^ bit_b);
  assign err_d  = ~(par_ai ^ cmp_db);

  // borrow checker: (bout ^ b) must equal the cases where a, b, bin disagree that way
  assign cmp_ob  = ~(brw_o ^ bit_b);
  assign odd_mix = (~bit_a & ~bit_b & brw_i) | (bit_a & bit_b & ~brw_i);
  assign err_o   = ~(cmp_ob ^ odd_mix);

endmodule

// File: rtl/fls_chain.sv
module fls_chain #(
  parameter int W = 8
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         brw_in,
  input  logic [W-1:0] flip_d,
  input  logic [W-1:0] flip_o,
  output logic [W-1:0] dif,
  output logic         brw_out,
  output logic [W-1:0] err_d,
  output logic [W-1:0] err_o
);

  logic [W:0] brw_link;

  assign brw_link[0] = brw_in;

  for (genvar g = 0; g < W; g++) begin : g_cell
    fls_cell u_cell (
      .bit_a  (op_a[g]),
      .bit_b  (op_b[g]),
      .brw_i  (brw_link[g]),
      .flip_d (flip_d[g]),
      .flip_o (flip_o[g]),
      .dif_o  (dif[g]),
      .brw_o  (brw_link[g+1]),
      .err_d  (err_d[g]),
      .err_o  (err_o[g])
    );
  end

  assign brw_out = brw_link[W];

endmodule

// File: rtl/fls_locator.sv
module fls_locator
  import fls_pkg::*;
#(
  parameter int W    = 8,
  parameter int IDXW = 3
) (
  input  logic [W-1:0]    err_d,
  input  logic [W-1:0]    err_o,
  output logic            hit,
  output logic [IDXW-1:0] idx,
  output net_code_t       net
);

  // scan from the top down so the lowest flagged bit wins
  always_comb begin
    hit = 1'b0;
    idx = '0;
    net = NET_NONE;
    for (int i = W - 1; i >= 0; i--) begin
      if (err_d[i] | err_o[i]) begin
        hit = 1'b1;
        idx = IDXW'(i);
        net = net_code_t'({err_o[i], err_d[i]});
      end
    end
  end

endmodule

// File: rtl/fault_located_subtractor.sv
module fault_located_subtractor
  import fls_pkg::*;
#(
  parameter int W    = 8,
  parameter int IDXW = fls_pkg::idx_bits(W)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic            borrow_in,
  input  logic [W-1:0]    inj_diff,
  input  logic [W-1:0]    inj_borrow,
  output logic            out_valid,
  output logic [W-1:0]    diff,
  output logic            borrow_out,
  output logic [W-1:0]    flag_d,
  output logic [W-1:0]    flag_b,
  output logic            loc_valid,
  output logic [IDXW-1:0] loc_index,
  output logic [1:0]      loc_net
);

  logic [W-1:0]    c_dif, c_err_d, c_err_o;
  logic            c_brw;
  logic            c_hit;
  logic [IDXW-1:0] c_idx;
  net_code_t       c_net;

  fls_chain #(.W(W)) u_chain (
    .op_a    (a),
    .op_b    (b),
    .brw_in  (borrow_in),
    .flip_d  (inj_diff),
    .flip_o  (inj_borrow),
    .dif     (c_dif),
    .brw_out (c_brw),
    .err_d   (c_err_d),
    .err_o   (c_err_o)
  );

  fls_locator #(.W(W), .IDXW(IDXW)) u_loc (
    .err_d (c_err_d),
    .err_o (c_err_o),
    .hit   (c_hit),
    .idx   (c_idx),
    .net   (c_net)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      diff       <= '0;
      borrow_out <= 1'b0;
      flag_d     <= '0;
      flag_b     <= '0;
      loc_valid  <= 1'b0;
      loc_index  <= '0;
      loc_net    <= 2'b00;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        diff       <= c_dif;
        borrow_out <= c_brw;
        flag_d     <= c_err_d;
        flag_b     <= c_err_o;
        loc_valid  <= c_hit;
        loc_index  <= c_idx;
        loc_net    <= c_net;
      end
    end
  end

  // R1: clean arithmetic
  a_r1_clean_result: assert property (@(posedge clk) disable iff (rst)
    (in_valid && inj_diff == '0 && inj_borrow == '0) |=>
      ({borrow_out, diff} == $past({1'b0, a} - {1'b0, b} - {{W{1'b0}}, borrow_in})));

  // R2: one-cycle strobe delay and hold
  a_r2_valid_delay: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(diff) && $stable(flag_d) && $stable(flag_b)));

  // R3: no false alarms
  a_r3_no_false_flag: assert property (@(posedge clk) disable iff (rst)
    (in_valid && inj_diff == '0 && inj_borrow == '0) |=> (flag_d == '0 && flag_b == '0));

  // R4 / R5: every inserted fault is seen on its own net
  a_r4_diff_flags: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (flag_d == $past(inj_diff)));
  a_r5_borrow_flags: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (flag_b == $past(inj_borrow)));

  // R7: report names the lowest flagged bit and its nets
  a_r7_lowest_bit: assert property (@(posedge clk) disable iff (rst)
    (out_valid && loc_valid) |->
      ((((flag_d | flag_b) >> loc_index) & W'(1)) == W'(1) &&
       ((flag_d | flag_b) & ((W'(1) << loc_index) - W'(1))) == '0 &&
       loc_net == {flag_b[loc_index], flag_d[loc_index]}));

  // R8: report valid tracks the flag vectors
  a_r8_report_valid: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (loc_valid == ((flag_d | flag_b) != '0)));

  // R9: reset clears outputs
  a_r9_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && !loc_valid && flag_d == '0 && flag_b == '0 && diff == '0));

endmodule

// File: tb/sim_fault_located_subtractor.sv
module sim_fault_located_subtractor;

  localparam int W    = 4;
  localparam int IDXW = (W > 1) ? $clog2(W) : 1;

  typedef struct {
    logic [W-1:0]    d;
    logic            bo;
    logic [W-1:0]    fd;
    logic [W-1:0]    fb;
    logic            lv;
    logic [IDXW-1:0] li;
    logic [1:0]      ln;
    string           rq_res;
    string           rq_flg;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic [W-1:0]    a = '0, b = '0, inj_diff = '0, inj_borrow = '0;
  logic            borrow_in = 1'b0;
  logic            out_valid, borrow_out, loc_valid;
  logic [W-1:0]    diff, flag_d, flag_b;
  logic [IDXW-1:0] loc_index;
  logic [1:0]      loc_net;

  int   n_chk = 0;
  int   n_err = 0;
  exp_t sb[$];
  exp_t last;
  bit   have_last = 0;

  always #10 clk = ~clk;

  fault_located_subtractor #(.W(W)) u0 (
    .clk, .rst, .in_valid, .a, .b, .borrow_in, .inj_diff, .inj_borrow,
    .out_valid, .diff, .borrow_out, .flag_d, .flag_b,
    .loc_valid, .loc_index, .loc_net
  );

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [W-1:0] xa, input logic [W-1:0] xb,
                                 input logic xbi, input logic [W-1:0] md,
                                 input logic [W-1:0] mb);
    exp_t e;
    logic br;
    br = xbi;
    for (int i = 0; i < W; i++) begin
      e.d[i] = xa[i] ^ xb[i] ^ br ^ md[i];
      br = ((!xa[i] && xb[i]) || (!xa[i] && br) || (xb[i] && br)) ^ mb[i];
    end
    e.bo = br;
    e.fd = md;
    e.fb = mb;
    e.lv = ((md | mb) != '0);
    e.li = '0;
    e.ln = 2'b00;
    for (int i = W - 1; i >= 0; i--)
      if (md[i] || mb[i]) begin
        e.li = IDXW'(i);
        e.ln = {mb[i], md[i]};
      end
    e.rq_res = ((md | mb) == '0) ? "R1" : "R10";
    if ((md | mb) == '0)      e.rq_flg = "R3";
    else if ((md & mb) != '0) e.rq_flg = "R6";
    else if (mb == '0)        e.rq_flg = "R4";
    else if (md == '0)        e.rq_flg = "R5";
    else                      e.rq_flg = "R4";
    return e;
  endfunction

  task automatic send(input logic [W-1:0] xa, input logic [W-1:0] xb, input logic xbi,
                      input logic [W-1:0] md, input logic [W-1:0] mb);
    @(negedge clk);
    a = xa; b = xb; borrow_in = xbi; inj_diff = md; inj_borrow = mb;
    in_valid = 1'b1;
    sb.push_back(model(xa, xb, xbi, md, mb));
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      a = ~a; b = ~b; inj_diff = ~inj_diff; inj_borrow = ~inj_borrow;
    end
  endtask

  task automatic check_cleared(input string tag);
    check(out_valid == 0 && loc_valid == 0, "R9", {tag, " valids"},
          {out_valid, loc_valid}, 0);
    check(diff == 0 && borrow_out == 0, "R9", {tag, " result"}, {borrow_out, diff}, 0);
    check(flag_d == 0 && flag_b == 0, "R9", {tag, " flags"}, {flag_d, flag_b}, 0);
    check(loc_index == 0 && loc_net == 0, "R9", {tag, " report"}, {loc_index, loc_net}, 0);
  endtask

  // monitor: compare each result against the scoreboard head
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (sb.size() == 0) begin
        check(0, "R2", "unexpected out_valid", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({borrow_out, diff} == {e.bo, e.d}, e.rq_res, "result",
              {borrow_out, diff}, {e.bo, e.d});
        check(flag_d == e.fd, e.rq_flg, "flag_d", flag_d, e.fd);
        check(flag_b == e.fb, e.rq_flg, "flag_b", flag_b, e.fb);
        check(loc_valid == e.lv, "R8", "loc_valid", loc_valid, e.lv);
        if (e.lv)
          check(loc_index == e.li && loc_net == e.ln, "R7", "location",
                {loc_index, loc_net}, {e.li, e.ln});
        else
          check(loc_index == 0 && loc_net == 0, "R8", "empty report",
                {loc_index, loc_net}, 0);
        last = e;
        have_last = 1;
      end
    end
  end

  bit done = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_cleared("initial reset");
    rst = 1'b0;

    // R1 R3: full operand sweep without faults
    for (int xa = 0; xa < (1 << W); xa++)
      for (int xb = 0; xb < (1 << W); xb++)
        for (int xc = 0; xc < 2; xc++)
          send(W'(xa), W'(xb), xc[0], '0, '0);
    idle(2);

    // R2: outputs hold while idle
    repeat (2) @(negedge clk);
    check(out_valid == 0, "R2", "no strobe while idle", out_valid, 0);
    check(have_last && diff == last.d && borrow_out == last.bo, "R2", "result held",
          {borrow_out, diff}, {last.bo, last.d});

    // R4 R5 R6 R10: single and same-bit double faults at each position
    for (int i = 0; i < W; i++)
      for (int p = 0; p < 4; p++) begin
        logic [W-1:0] opa, opb;
        opa = W'(p * 5 + i);
        opb = W'(p * 3 + 7);
        send(opa, opb, p[0], W'(1) << i, '0);
        send(opa, opb, p[1], '0, W'(1) << i);
        send(opa, opb, p[0], W'(1) << i, W'(1) << i);
      end

    // R7: different faulty bits, lowest must be reported
    for (int i = 0; i < W; i++)
      for (int j = 0; j < W; j++)
        if (i != j) begin
          send(W'(i + 2 * j), W'(j), 1'b0, W'(1) << i, W'(1) << j);
          send(W'(j), W'(i), 1'b1, (W'(1) << i) | (W'(1) << j), '0);
        end

    // R10: borrow fault ripples into every bit above it
    send('0, '0, 1'b0, '0, W'(1));
    idle(3);

    // R9: reset after activity
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check_cleared("reset after traffic");
    rst = 1'b0;
    send(W'(3), W'(5), 1'b0, '0, '0);
    idle(3);
    check(sb.size() == 0, "R2", "scoreboard drained", sb.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule